// File: doc/BRIEF.md
# Line printer column formatter

This block sits between a stream of 8-bit print codes and a 132-column printer. It keeps a column count for the current line and turns each incoming code into whatever the printer needs: printable characters, runs of spaces for tabs, a carriage return, or a request to move the paper. Paper moves go to a separate request/acknowledge interface. Characters leave one per cycle on a valid/ready output. Code translation and the vertical format table are handled outside this block.

A code is taken on the input handshake only while the block is idle. A tab turns into several output characters, so `in_ready` stays low until the last space has been handed over. When a line is already full, the block first asks for a one-line advance. The character, or the tab's spaces, follow only after that request is acknowledged.

Top module: `lp_col_formatter`

## Requirements
- R1: Only the low 7 bits of `in_code` are used. Bit 7 has no effect on output, paper motion or column.
- R2: Code 0 is accepted with no output character, no paper request and no change to `col`.
- R3: Code 012 (octal) raises a paper request with `mot_kind` 0 (one line). Code 014 raises one with `mot_kind` 1 (top of form). Neither emits a character, and both leave `col` at 0.
- R4: Code 015 emits the character 7'o015 and leaves `col` at 0. That output does not count as a column.
- R5: A tab (011) with `col` below 128 emits 8 − (`col` mod 8) spaces (7'o040), which brings `col` to the next multiple of 8.
- R6: A tab with `col` at 128 or more first raises a one-line paper request. Once it is acknowledged, the tab emits 8 spaces and `col` ends at 8.
- R7: Any other code below 040 emits one space and adds 1 to `col`.
- R8: A character code (040 and up) emits itself. If `col` is 132 or more when it arrives, a one-line paper request comes first, and `col` ends at 1.
- R9: `col` rises by exactly 1 for each output transfer (`out_valid` and `out_ready` both high), except the carriage return. It never exceeds 132.
- R10: `out_valid` and `out_char` hold while `out_ready` is low. `mot_req` and `mot_kind` hold until `mot_ack`. `in_ready` stays low while a code is still producing output or waiting on a paper request.
- R11: After reset, `col` is 0, `in_ready` is 1, and `out_valid` and `mot_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A print code is offered |
| in_code | input | CODE_W | Print code |
| in_ready | output | 1 | Block is idle and will take a code |
| out_valid | output | 1 | Output character is valid |
| out_char | output | 7 | Character to the printer |
| out_ready | input | 1 | Printer takes the character |
| mot_req | output | 1 | Paper motion requested |
| mot_kind | output | 1 | 0 = one-line advance, 1 = top of form |
| mot_ack | input | 1 | Paper motion request taken |
| col | output | COL_W | Current column |

## Verification
A code is accepted on the rising edge where `in_valid` and `in_ready` are both high. Its first result appears in the cycle that follows: `out_valid` for a character, or `mot_req` for a paper move. A clear of `col` by LF, FF, CR or a wrap is already visible in that same cycle. Each later character comes one cycle after the previous transfer, and `col` increments on the edge of each transfer. The bench drives inputs just after the rising edge and logs transfers at the falling edge, so every event is recorded in the cycle it is due. It then compares the logged order and the final `col` after `in_ready` returns.

// File: rtl/lpfmt_pkg.sv
package lpfmt_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_MOVE = 2'd1,
    FS_EMIT = 2'd2
  } fmt_state_e;

  typedef enum logic {
    MV_LINE = 1'b0,
    MV_TOF  = 1'b1
  } move_kind_e;

  localparam logic [6:0] CH_NUL   = 7'o000;
  localparam logic [6:0] CH_TAB   = 7'o011;
  localparam logic [6:0] CH_LF    = 7'o012;
  localparam logic [6:0] CH_FF    = 7'o014;
  localparam logic [6:0] CH_CR    = 7'o015;
  localparam logic [6:0] CH_SPACE = 7'o040;

  // spaces needed to reach the next tab stop
  function automatic int unsigned tab_fill(input int unsigned column, input int unsigned stop);
    return stop - (column % stop);
  endfunction

  // control codes print as a blank
  function automatic logic [6:0] printable(input logic [6:0] c);
    return (c < CH_SPACE) ? CH_SPACE : c;
  endfunction

endpackage

// File: rtl/lpfmt_decode.sv
module lpfmt_decode
  import lpfmt_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned REP_W      = 4,
  parameter int unsigned LINE_WIDTH = 132,
  parameter int unsigned TAB_STOP   = 8,
  parameter int unsigned TAB_WRAP   = 128
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              move_o,
  output move_kind_e        kind_o,
  output logic [REP_W-1:0]  reps_o,
  output logic [6:0]        ch_o,
  output logic              counted_o,
  output logic              clear_o
);

  localparam logic [COL_W-1:0] WRAP_COL = COL_W'(TAB_WRAP);
  localparam logic [COL_W-1:0] FULL_COL = COL_W'(LINE_WIDTH);

  logic [6:0] c7;
  assign c7 = code_i[6:0];

  always_comb begin
    move_o    = 1'b0;
    kind_o    = MV_LINE;
    reps_o    = '0;
    ch_o      = CH_SPACE;
    counted_o = 1'b1;
    clear_o   = 1'b0;
    case (c7)
      CH_NUL: begin
        counted_o = 1'b1;
      end
      CH_LF: begin
        move_o  = 1'b1;
        clear_o = 1'b1;
      end
      CH_FF: begin
        move_o  = 1'b1;
        kind_o  = MV_TOF;
        clear_o = 1'b1;
      end
      CH_CR: begin
        reps_o    = REP_W'(1);
        ch_o      = CH_CR;
        counted_o = 1'b0;
        clear_o   = 1'b1;
      end
      CH_TAB: begin
        if (col_i >= WRAP_COL) begin
          move_o  = 1'b1;
          clear_o = 1'b1;
          reps_o  = REP_W'(TAB_STOP);
        end else begin
          reps_o = REP_W'(tab_fill(32'(col_i), TAB_STOP));
        end
      end
      default: begin
        ch_o   = printable(c7);
        reps_o = REP_W'(1);
        if (col_i >= FULL_COL) begin
          move_o  = 1'b1;
          clear_o = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/lpfmt_column.sv
module lpfmt_column #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [COL_W-1:0] col_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)       col_o <= '0;
    else if (clear_i) col_o <= '0;
    else if (step_i)  col_o <= col_o + COL_W'(1);
  end

endmodule

// File: rtl/lpfmt_seq.sv
module lpfmt_seq
  import lpfmt_pkg::*;
#(
  parameter int unsigned REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             move_i,
  input  move_kind_e       kind_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic [6:0]       ch_i,
  input  logic             counted_i,
  input  logic             out_ready_i,
  input  logic             mot_ack_i,
  output logic             in_ready_o,
  output logic             accept_o,
  output logic             out_valid_o,
  output logic [6:0]       out_char_o,
  output logic             mot_req_o,
  output move_kind_e       mot_kind_o,
  output logic             emit_fire_o,
  output logic             step_o
);

  fmt_state_e       state;
  logic [REP_W-1:0] reps_q;
  logic [6:0]       ch_q;
  logic             counted_q;
  move_kind_e       kind_q;

  assign in_ready_o  = (state == FS_IDLE);
  assign accept_o    = in_ready_o && in_valid_i;
  assign out_valid_o = (state == FS_EMIT);
  assign out_char_o  = ch_q;
  assign mot_req_o   = (state == FS_MOVE);
  assign mot_kind_o  = kind_q;
  assign emit_fire_o = out_valid_o && out_ready_i;
  assign step_o      = emit_fire_o && counted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      reps_q    <= '0;
      ch_q      <= CH_SPACE;
      counted_q <= 1'b0;
      kind_q    <= MV_LINE;
    end else begin
      case (state)
        FS_IDLE: begin
          if (in_valid_i) begin
            ch_q      <= ch_i;
            reps_q    <= reps_i;
            counted_q <= counted_i;
            kind_q    <= kind_i;
            if (move_i)              state <= FS_MOVE;
            else if (reps_i != '0)   state <= FS_EMIT;
          end
        end
        FS_MOVE: begin
          if (mot_ack_i) state <= (reps_q != '0) ? FS_EMIT : FS_IDLE;
        end
        FS_EMIT: begin
          if (out_ready_i) begin
            reps_q <= reps_q - REP_W'(1);
            if (reps_q == REP_W'(1)) state <= FS_IDLE;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lp_col_formatter.sv
module lp_col_formatter
  import lpfmt_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned LINE_WIDTH = 132,
  parameter int unsigned TAB_STOP   = 8,
  parameter int unsigned TAB_WRAP   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  output logic              out_valid,
  output logic [6:0]        out_char,
  input  logic              out_ready,
  output logic              mot_req,
  output logic              mot_kind,
  input  logic              mot_ack,
  output logic [COL_W-1:0]  col
);

  localparam int unsigned REP_W = $clog2(TAB_STOP + 1);

  logic             dec_move;
  move_kind_e       dec_kind;
  logic [REP_W-1:0] dec_reps;
  logic [6:0]       dec_ch;
  logic             dec_counted;
  logic             dec_clear;

  // named events for the checker
  logic       accept_fire;
  logic       emit_fire;
  logic       col_step;
  logic       col_clear;
  move_kind_e kind_e;

  lpfmt_decode #(
    .CODE_W(CODE_W), .COL_W(COL_W), .REP_W(REP_W),
    .LINE_WIDTH(LINE_WIDTH), .TAB_STOP(TAB_STOP), .TAB_WRAP(TAB_WRAP)
  ) u_decode (
    .code_i   (in_code),
    .col_i    (col),
    .move_o   (dec_move),
    .kind_o   (dec_kind),
    .reps_o   (dec_reps),
    .ch_o     (dec_ch),
    .counted_o(dec_counted),
    .clear_o  (dec_clear)
  );

  lpfmt_seq #(.REP_W(REP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid),
    .move_i     (dec_move),
    .kind_i     (dec_kind),
    .reps_i     (dec_reps),
    .ch_i       (dec_ch),
    .counted_i  (dec_counted),
    .out_ready_i(out_ready),
    .mot_ack_i  (mot_ack),
    .in_ready_o (in_ready),
    .accept_o   (accept_fire),
    .out_valid_o(out_valid),
    .out_char_o (out_char),
    .mot_req_o  (mot_req),
    .mot_kind_o (kind_e),
    .emit_fire_o(emit_fire),
    .step_o     (col_step)
  );

  assign mot_kind  = kind_e;
  assign col_clear = accept_fire && dec_clear;

  lpfmt_column #(.COL_W(COL_W)) u_column (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(col_clear),
    .step_i (col_step),
    .col_o  (col)
  );

endmodule

// File: rtl/lpfmt_checker.sv
module lpfmt_checker #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned LINE_WIDTH = 132
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] in_code,
  input logic              in_ready,
  input logic              out_valid,
  input logic [6:0]        out_char,
  input logic              out_ready,
  input logic              mot_req,
  input logic              mot_kind,
  input logic              mot_ack,
  input logic [COL_W-1:0]  col,
  input logic              accept_fire,
  input logic              emit_fire
);

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));

  a_r10_move_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mot_req && !mot_ack) |=> (mot_req && $stable(mot_kind)));

  a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || mot_req) |-> !in_ready);

  a_r9_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_fire && out_char != 7'o015) |=> (col == COL_W'($past(col) + 1'b1)));

  a_r4_cr_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_fire && out_char == 7'o015) |=> $stable(col));

  a_r9_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_W'(LINE_WIDTH));

  a_r3_move_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mot_req |-> (col == '0));

  a_r2_nul_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_fire && in_code[6:0] == 7'd0) |=> (in_ready && $stable(col)));

endmodule

bind lp_col_formatter lpfmt_checker #(
  .CODE_W(CODE_W), .COL_W(COL_W), .LINE_WIDTH(LINE_WIDTH)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_code    (in_code),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_char   (out_char),
  .out_ready  (out_ready),
  .mot_req    (mot_req),
  .mot_kind   (mot_kind),
  .mot_ack    (mot_ack),
  .col        (col),
  .accept_fire(accept_fire),
  .emit_fire  (emit_fire)
);

// File: tb/tb_lp_col_formatter.sv
module tb_lp_col_formatter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_code = 8'd0;
  logic       in_ready;
  logic       out_valid;
  logic [6:0] out_char;
  logic       out_ready = 1'b1;
  logic       mot_req;
  logic       mot_kind;
  logic       mot_ack = 1'b0;
  logic [7:0] col;

  logic ack_en = 1'b1;
  bit   finished = 1'b0;
  int   checks = 0;
  int   errors = 0;

  // event log: kind 0 = character, 1 = paper request
  int log_kind [64];
  int log_val  [64];
  int log_n = 0;

  lp_col_formatter dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_code(in_code), .in_ready(in_ready),
    .out_valid(out_valid), .out_char(out_char), .out_ready(out_ready),
    .mot_req(mot_req), .mot_kind(mot_kind), .mot_ack(mot_ack),
    .col(col)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready && log_n < 64) begin
        log_kind[log_n] = 0; log_val[log_n] = int'(out_char); log_n++;
      end
      if (rst_n && mot_req && mot_ack && log_n < 64) begin
        log_kind[log_n] = 1; log_val[log_n] = int'(mot_kind); log_n++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      mot_ack = mot_req && ack_en;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic clear_log();
    log_n = 0;
  endtask

  task automatic check_entry(input string req, input int idx, input int kind, input int val);
    check_eq(req, $sformatf("log[%0d] kind", idx), log_kind[idx], kind);
    check_eq(req, $sformatf("log[%0d] value", idx), log_val[idx], val);
  endtask

  task automatic start(input logic [7:0] c);
    @(posedge clk); #1;
    in_valid = 1'b1; in_code = c;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic send(input logic [7:0] c);
    start(c);
    wait_idle();
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) send(8'h78);
  endtask

  task automatic home();
    send(8'o012);
    clear_log();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R11", "col after reset", int'(col), 0);
    check_eq("R11", "in_ready after reset", int'(in_ready), 1);
    check_eq("R11", "out_valid after reset", int'(out_valid), 0);
    check_eq("R11", "mot_req after reset", int'(mot_req), 0);
  endtask

  task automatic t_plain_and_mask();
    home();
    send(8'h41);
    send(8'hC2);
    check_eq("R1", "events for A and masked B", log_n, 2);
    check_entry("R1", 0, 0, 8'h41);
    check_entry("R1", 1, 0, 8'h42);
    check_eq("R9", "col after two chars", int'(col), 2);
    clear_log();
    send(8'h8A);
    check_eq("R1", "masked LF events", log_n, 1);
    check_entry("R1", 0, 1, 0);
    check_eq("R1", "col after masked LF", int'(col), 0);
  endtask

  task automatic t_nul();
    home();
    fill(3);
    clear_log();
    send(8'h00);
    send(8'h80);
    check_eq("R2", "events for NUL", log_n, 0);
    check_eq("R2", "col after NUL", int'(col), 3);
  endtask

  task automatic t_cr_lf_ff();
    home();
    fill(5);
    clear_log();
    send(8'o015);
    check_eq("R4", "CR events", log_n, 1);
    check_entry("R4", 0, 0, 8'o015);
    check_eq("R4", "col after CR", int'(col), 0);
    fill(4);
    clear_log();
    send(8'o012);
    check_eq("R3", "LF events", log_n, 1);
    check_entry("R3", 0, 1, 0);
    check_eq("R3", "col after LF", int'(col), 0);
    fill(6);
    clear_log();
    send(8'o014);
    check_eq("R3", "FF events", log_n, 1);
    check_entry("R3", 0, 1, 1);
    check_eq("R3", "col after FF", int'(col), 0);
  endtask

  task automatic t_ctrl_space();
    home();
    send(8'o007);
    send(8'o037);
    check_eq("R7", "control code events", log_n, 2);
    check_entry("R7", 0, 0, 8'o040);
    check_entry("R7", 1, 0, 8'o040);
    check_eq("R7", "col after two control codes", int'(col), 2);
  endtask

  task automatic t_tab_mid();
    home();
    fill(3);
    clear_log();
    send(8'o011);
    check_eq("R5", "spaces from col 3", log_n, 5);
    check_entry("R5", 4, 0, 8'o040);
    check_eq("R5", "col after tab from 3", int'(col), 8);
    clear_log();
    send(8'o011);
    check_eq("R5", "spaces from col 8", log_n, 8);
    check_eq("R5", "col after tab from 8", int'(col), 16);
  endtask

  task automatic t_tab_wrap();
    home();
    fill(127);
    clear_log();
    send(8'o011);
    check_eq("R5", "spaces from col 127", log_n, 1);
    check_eq("R5", "col after tab from 127", int'(col), 128);
    clear_log();
    send(8'o011);
    check_eq("R6", "events for tab at 128", log_n, 9);
    check_entry("R6", 0, 1, 0);
    check_entry("R6", 1, 0, 8'o040);
    check_entry("R6", 8, 0, 8'o040);
    check_eq("R6", "col after wrapping tab", int'(col), 8);
  endtask

  task automatic t_line_full();
    home();
    fill(132);
    check_eq("R8", "no wrap before col 132", log_n, 132 > 64 ? 64 : 132);
    check_eq("R9", "col at full line", int'(col), 132);
    clear_log();
    send(8'h5A);
    check_eq("R8", "events for char at 132", log_n, 2);
    check_entry("R8", 0, 1, 0);
    check_entry("R8", 1, 0, 8'h5A);
    check_eq("R8", "col after wrap", int'(col), 1);
  endtask

  task automatic t_stalls();
    home();
    out_ready = 1'b0;
    start(8'o011);
    repeat (3) @(negedge clk);
    check_eq("R10", "out_valid held", int'(out_valid), 1);
    check_eq("R10", "out_char held", int'(out_char), 8'o040);
    check_eq("R10", "in_ready low while emitting", int'(in_ready), 0);
    check_eq("R10", "nothing transferred during stall", log_n, 0);
    check_eq("R10", "col unchanged during stall", int'(col), 0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    wait_idle();
    check_eq("R10", "spaces after stall", log_n, 8);
    check_eq("R10", "col after stalled tab", int'(col), 8);
    clear_log();
    ack_en = 1'b0;
    start(8'o014);
    repeat (3) @(negedge clk);
    check_eq("R10", "mot_req held", int'(mot_req), 1);
    check_eq("R10", "mot_kind held", int'(mot_kind), 1);
    check_eq("R10", "in_ready low while moving", int'(in_ready), 0);
    ack_en = 1'b1;
    wait_idle();
    check_eq("R10", "one request after ack", log_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_plain_and_mask();
    t_nul();
    t_cr_lf_ff();
    t_ctrl_space();
    t_tab_mid();
    t_tab_wrap();
    t_line_full();
    t_stalls();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule